// File: doc/BRIEF.md
# Low-Power DRAM Power-State Monitor

This block watches the control pins of a mobile low-power DRAM from the controller side. It samples clock-enable, chip select and a decoded command code on each rising clock edge. From these it follows the device through its power states: power-on, idle, bank-active, resetting, and the power-down family (active power-down, idle power-down, resetting power-down, self refresh and deep power-down). Each transition is decided from two clock-enable samples, the one taken at the previous edge and the one taken at the current edge, together with the chip select and command of the current edge.

Leaving a power-down or self refresh opens a guard window. Its length in cycles comes from a configuration input. While the window is open, `busy` is high and only NOP is allowed. Any step the monitor does not recognise, and any command issued inside a guard window, raises a sticky `violation` flag and leaves the tracked state where it was. A separate initialisation interval starts with each accepted reset command and decides where the resetting states lead.

Top module: `pwr_state_monitor`

## Requirements
- R1: After a synchronous active-low reset, `state` is power-on (code 0), `busy` and `violation` are 0, the previous clock-enable sample is low, and both timers are cleared. State codes: 0 power-on, 1 idle, 2 bank-active, 3 active power-down, 4 idle power-down, 5 self refresh, 6 deep power-down, 7 resetting, 8 resetting power-down.
- R2: A step counts as NOP when `cs_n` is 1 or `cmd` is 0. The command codes are 1 activate, 2 precharge-all, 3 reset, 4 self-refresh entry and 5 deep-power-down entry; 6 and 7 are other commands. With clock-enable high on both edges: activate moves idle to bank-active; precharge-all moves bank-active to idle; reset moves power-on, idle, bank-active or resetting to resetting and restarts the initialisation interval. Any other command leaves the state unchanged.
- R3: In resetting, with clock-enable high on both edges and no reset command, the state moves to idle at the first edge where the initialisation interval has expired. The interval is loaded with `tinit5_cycles` at the reset-command edge, so the state reads resetting for `tinit5_cycles`+1 sampled cycles.
- R4: Clock-enable going high-to-low on a NOP step moves bank-active to active power-down, idle to idle power-down, and resetting to resetting power-down.
- R5: From idle, clock-enable going high-to-low with a self-refresh entry command (code 4) moves to self refresh. With a deep-power-down command (code 5) it moves to deep power-down.
- R6: With clock-enable low on both edges, self refresh, deep power-down and the three power-down states hold, whatever `cs_n` and `cmd` are.
- R7: Clock-enable going low-to-high on a NOP step leaves the low-power states as follows: active power-down goes to bank-active, idle power-down to idle, self refresh to idle, and deep power-down to power-on. Resetting power-down goes to idle if the initialisation interval has expired, and to resetting otherwise.
- R8: Leaving a power-down state loads the guard window with `txp_cycles`; leaving self refresh loads it with `txsr_cycles`. `busy` is high for exactly that many sampled cycles. A non-NOP command at an edge where `busy` is high raises `violation` and leaves the state unchanged.
- R9: Every other combination of state and clock-enable pair raises `violation` and leaves the state unchanged. This includes: low on both edges in idle, bank-active or resetting; low-to-high outside the low-power states or with a non-NOP command; high-to-low from power-on, or with any other command; high on both edges in any low-power state.
- R10: `violation` stays at 1 until reset, whatever steps follow.
- R11: In power-on, clock-enable low on both edges, or low-to-high, holds the state legally with any `cs_n` and `cmd`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cke | input | 1 | Clock-enable level at this edge |
| cs_n | input | 1 | Chip select, active low |
| cmd | input | 3 | Decoded command code |
| txp_cycles | input | CNT_W | Guard window after a power-down exit, in cycles |
| txsr_cycles | input | CNT_W | Guard window after a self-refresh exit, in cycles |
| tinit5_cycles | input | CNT_W | Initialisation interval after a reset command, in cycles |
| state | output | 4 | Tracked power state code |
| busy | output | 1 | Guard window open |
| violation | output | 1 | Sticky illegal-step flag |

## Verification
The bench builds the block with `CNT_W` = 4, so every window and interval fits into a few cycles. This keeps a full sweep small: each of ten starting conditions (power-on with either previous clock-enable level, plus the eight other states) is reached from reset and hit with every clock-enable level, chip-select level and command code. The next state and the violation flag are predicted from the transition rules. With windows of 3 and 5 cycles and an interval of 4, the bench can count the exact busy and resetting lengths and probe a command on the last busy cycle and on the first free one.

// File: rtl/pwr_mon_pkg.sv
// Package: shared state encoding and command codes for the power-state monitor.
// Assumes commands arrive already decoded into a 3-bit code.
package pwr_mon_pkg;

    typedef enum logic [3:0] {
        ST_POWER_ON  = 4'd0,
        ST_IDLE      = 4'd1,
        ST_ACTIVE    = 4'd2,
        ST_ACT_PDN   = 4'd3,
        ST_IDLE_PDN  = 4'd4,
        ST_SELF_REF  = 4'd5,
        ST_DEEP_PDN  = 4'd6,
        ST_RESETTING = 4'd7,
        ST_RST_PDN   = 4'd8
    } pm_state_e;

    localparam logic [2:0] CMD_NOP           = 3'd0;
    localparam logic [2:0] CMD_ACTIVATE      = 3'd1;
    localparam logic [2:0] CMD_PRECHARGE_ALL = 3'd2;
    localparam logic [2:0] CMD_RESET         = 3'd3;
    localparam logic [2:0] CMD_SELF_REF      = 3'd4;
    localparam logic [2:0] CMD_DEEP_PDN      = 3'd5;

    // True for states in which clock-enable is expected to stay low.
    function automatic logic is_low_power(pm_state_e s);
        return (s == ST_ACT_PDN) || (s == ST_IDLE_PDN) || (s == ST_SELF_REF) ||
               (s == ST_DEEP_PDN) || (s == ST_RST_PDN);
    endfunction

endpackage

// File: rtl/pwr_mon_down_counter.sv
// Module: loadable down-counter that stops at zero; `active` is high while
// the count is non-zero. Assumes a load takes priority over counting down.
module pwr_mon_down_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         active
);
    localparam logic [W-1:0] ZERO = '0;
    localparam logic [W-1:0] ONE  = W'(1);

    logic [W-1:0] cnt;

    // Load a new window, or count the open one down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= ZERO;
        else if (load)
            cnt <= load_val;
        else if (cnt != ZERO)
            cnt <= cnt - ONE;
    end

    // Drive the open-window flag.
    always_comb active = (cnt != ZERO);

    // R8: an open window shrinks by one each cycle without a load
    a_r8_countdown: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && cnt != ZERO) |=> (cnt == $past(cnt) - ONE));

    // R1: a load of zero leaves no window open
    a_r1_zero_load: assert property (@(posedge clk) disable iff (!rst_n)
        (load && load_val == ZERO) |=> !active);

endmodule

// File: rtl/pwr_mon_next_state.sv
// Module: combinational transition rules. From the current state, the
// previous and current clock-enable samples, chip select, command, guard
// status and init status it computes the next state, a legality flag and the
// timer load strobes. Assumes the caller registers the result.
module pwr_mon_next_state
    import pwr_mon_pkg::*;
(
    input  pm_state_e  cur,
    input  logic       cke_prev,
    input  logic       cke,
    input  logic       cs_n,
    input  logic [2:0] cmd,
    input  logic       guard_open,
    input  logic       init_done,
    output pm_state_e  nxt,
    output logic       legal,
    output logic       load_xp,
    output logic       load_xsr,
    output logic       load_init
);
    logic is_nop;

    // Classify the step as NOP or a real command.
    always_comb is_nop = cs_n || (cmd == CMD_NOP);

    // Evaluate the transition table for this edge.
    always_comb begin
        nxt       = cur;
        legal     = 1'b1;
        load_xp   = 1'b0;
        load_xsr  = 1'b0;
        load_init = 1'b0;
        case ({cke_prev, cke})
            2'b00: begin
                if (!(is_low_power(cur) || cur == ST_POWER_ON))
                    legal = 1'b0;
            end
            2'b01: begin
                if (cur == ST_POWER_ON) begin
                    legal = 1'b1;
                end else if (!is_nop) begin
                    legal = 1'b0;
                end else begin
                    case (cur)
                        ST_ACT_PDN:  begin nxt = ST_ACTIVE;   load_xp  = 1'b1; end
                        ST_IDLE_PDN: begin nxt = ST_IDLE;     load_xp  = 1'b1; end
                        ST_SELF_REF: begin nxt = ST_IDLE;     load_xsr = 1'b1; end
                        ST_DEEP_PDN: nxt = ST_POWER_ON;
                        ST_RST_PDN: begin
                            nxt     = init_done ? ST_IDLE : ST_RESETTING;
                            load_xp = 1'b1;
                        end
                        default: legal = 1'b0;
                    endcase
                end
            end
            2'b10: begin
                if (is_nop) begin
                    case (cur)
                        ST_ACTIVE:    nxt = ST_ACT_PDN;
                        ST_IDLE:      nxt = ST_IDLE_PDN;
                        ST_RESETTING: nxt = ST_RST_PDN;
                        default:      legal = 1'b0;
                    endcase
                end else if (cur == ST_IDLE && cmd == CMD_SELF_REF) begin
                    nxt = ST_SELF_REF;
                end else if (cur == ST_IDLE && cmd == CMD_DEEP_PDN) begin
                    nxt = ST_DEEP_PDN;
                end else begin
                    legal = 1'b0;
                end
            end
            default: begin
                if (is_low_power(cur)) begin
                    legal = 1'b0;
                end else if (!is_nop && cmd == CMD_RESET) begin
                    nxt       = ST_RESETTING;
                    load_init = 1'b1;
                end else if (!is_nop && cmd == CMD_ACTIVATE && cur == ST_IDLE) begin
                    nxt = ST_ACTIVE;
                end else if (!is_nop && cmd == CMD_PRECHARGE_ALL && cur == ST_ACTIVE) begin
                    nxt = ST_IDLE;
                end else if (cur == ST_RESETTING && init_done) begin
                    nxt = ST_IDLE;
                end
            end
        endcase
        if (guard_open && !is_nop)
            legal = 1'b0;
        if (!legal) begin
            nxt       = cur;
            load_xp   = 1'b0;
            load_xsr  = 1'b0;
            load_init = 1'b0;
        end
    end

endmodule

// File: rtl/pwr_state_monitor.sv
// Module: top of the power-state monitor. It registers the clock-enable
// history, the tracked state and the sticky violation flag, and runs one
// guard-window timer and one initialisation timer. Assumes all inputs are
// synchronous to clk and the configuration inputs are stable while a timer
// load can occur.
module pwr_state_monitor
    import pwr_mon_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cke,
    input  logic             cs_n,
    input  logic [2:0]       cmd,
    input  logic [CNT_W-1:0] txp_cycles,
    input  logic [CNT_W-1:0] txsr_cycles,
    input  logic [CNT_W-1:0] tinit5_cycles,
    output logic [3:0]       state,
    output logic             busy,
    output logic             violation
);
    pm_state_e        cur_state;
    pm_state_e        nxt_state;
    logic             cke_prev;
    logic             step_legal;
    logic             load_xp;
    logic             load_xsr;
    logic             load_init;
    logic             guard_open;
    logic             init_running;
    logic             exit_load;
    logic [CNT_W-1:0] exit_len;

    // Transition rules for this edge.
    pwr_mon_next_state u_rules (
        .cur        (cur_state),
        .cke_prev   (cke_prev),
        .cke        (cke),
        .cs_n       (cs_n),
        .cmd        (cmd),
        .guard_open (guard_open),
        .init_done  (!init_running),
        .nxt        (nxt_state),
        .legal      (step_legal),
        .load_xp    (load_xp),
        .load_xsr   (load_xsr),
        .load_init  (load_init)
    );

    // Pick the guard length for the kind of exit taken.
    always_comb begin
        exit_load = load_xp || load_xsr;
        exit_len  = load_xsr ? txsr_cycles : txp_cycles;
    end

    // Guard window opened by power-down and self-refresh exits.
    pwr_mon_down_counter #(.W(CNT_W)) u_exit_win (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (exit_load),
        .load_val (exit_len),
        .active   (guard_open)
    );

    // Initialisation interval started by an accepted reset command.
    pwr_mon_down_counter #(.W(CNT_W)) u_init_win (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load_init),
        .load_val (tinit5_cycles),
        .active   (init_running)
    );

    // Register clock-enable history, state and the sticky flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cke_prev  <= 1'b0;
            cur_state <= ST_POWER_ON;
            violation <= 1'b0;
        end else begin
            cke_prev  <= cke;
            cur_state <= nxt_state;
            violation <= violation || !step_legal;
        end
    end

    // Drive the output ports.
    always_comb begin
        state = cur_state;
        busy  = guard_open;
    end

    // R9: an illegal step keeps the state and raises the flag
    a_r9_illegal_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !step_legal |=> ($stable(state) && violation));

    // R10: the flag never drops without reset
    a_r10_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        violation |=> violation);

    // R6: self refresh and deep power-down hold while clock-enable stays low
    a_r6_low_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!cke_prev && !cke && (cur_state == ST_SELF_REF || cur_state == ST_DEEP_PDN))
        |=> $stable(state));

    // R8: a command inside the guard window is flagged
    a_r8_guard_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !cs_n && cmd != CMD_NOP) |=> violation);

    // R8: a power-down exit with a non-zero length opens the window
    a_r8_exit_opens: assert property (@(posedge clk) disable iff (!rst_n)
        (load_xp && txp_cycles != '0) |=> busy);

    // R4: a high-to-low NOP step from bank-active lands in active power-down
    a_r4_act_pdn: assert property (@(posedge clk) disable iff (!rst_n)
        (cke_prev && !cke && cs_n && !busy && cur_state == ST_ACTIVE)
        |=> (state == 4'd3));

endmodule

// File: tb/pwr_state_monitor_bench.sv
module pwr_state_monitor_bench;
    localparam int W = 4;
    localparam logic [3:0] S_PO = 0, S_IDLE = 1, S_ACT = 2, S_APD = 3, S_IPD = 4,
                           S_SR = 5, S_DPD = 6, S_RST = 7, S_RPD = 8;
    localparam logic [2:0] K_NOP = 0, K_ACT = 1, K_PREA = 2, K_RST = 3, K_SREF = 4, K_DPD = 5;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic         rst_n = 1'b0;
    logic         cke = 1'b0;
    logic         cs_n = 1'b1;
    logic [2:0]   cmd = 3'd0;
    logic [W-1:0] txp = '0;
    logic [W-1:0] txsr = '0;
    logic [W-1:0] tinit = '0;
    logic [3:0]   state;
    logic         busy;
    logic         violation;

    int n_checks = 0;
    int n_fail = 0;

    pwr_state_monitor #(.CNT_W(W)) u_pwr_state_monitor (
        .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .cmd(cmd),
        .txp_cycles(txp), .txsr_cycles(txsr), .tinit5_cycles(tinit),
        .state(state), .busy(busy), .violation(violation)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic step(input logic c, input logic csn, input logic [2:0] k);
        @(negedge clk);
        cke = c; cs_n = csn; cmd = k;
        @(posedge clk);
        #1;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; cke = 1'b0; cs_n = 1'b1; cmd = K_NOP;
        txp = '0; txsr = '0; tinit = '0;
        @(posedge clk); @(posedge clk); #1;
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic reach_idle();
        tinit = '0;
        step(1, 1, K_NOP);
        step(1, 0, K_RST);
        step(1, 1, K_NOP);
        tinit = 4'd15;
    endtask

    task automatic reach_resetting();
        tinit = 4'd15;
        step(1, 1, K_NOP);
        step(1, 0, K_RST);
    endtask

    // Expected {legal, next} from the transition rules.
    function automatic logic [4:0] model(input logic [3:0] st, input logic p, input logic c,
                                         input logic csn, input logic [2:0] k, input logic iexp);
        logic nop;
        logic lp;
        logic [3:0] nx;
        logic ok;
        nop = csn || (k == K_NOP);
        lp = (st == S_APD) || (st == S_IPD) || (st == S_SR) || (st == S_DPD) || (st == S_RPD);
        nx = st; ok = 1'b1;
        if (!p && !c) begin
            ok = lp || (st == S_PO);
        end else if (!p && c) begin
            if (st == S_PO) ok = 1'b1;
            else if (!nop) ok = 1'b0;
            else if (st == S_APD) nx = S_ACT;
            else if (st == S_IPD || st == S_SR) nx = S_IDLE;
            else if (st == S_DPD) nx = S_PO;
            else if (st == S_RPD) nx = iexp ? S_IDLE : S_RST;
            else ok = 1'b0;
        end else if (p && !c) begin
            if (nop && st == S_ACT) nx = S_APD;
            else if (nop && st == S_IDLE) nx = S_IPD;
            else if (nop && st == S_RST) nx = S_RPD;
            else if (!nop && st == S_IDLE && k == K_SREF) nx = S_SR;
            else if (!nop && st == S_IDLE && k == K_DPD) nx = S_DPD;
            else ok = 1'b0;
        end else begin
            if (lp) ok = 1'b0;
            else if (!nop && k == K_RST) nx = S_RST;
            else if (!nop && k == K_ACT && st == S_IDLE) nx = S_ACT;
            else if (!nop && k == K_PREA && st == S_ACT) nx = S_IDLE;
            else if (st == S_RST && iexp) nx = S_IDLE;
        end
        if (!ok) nx = st;
        return {ok, nx};
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        logic [3:0] st;
        logic pv;
        logic ie;
        logic [4:0] m;
        string tag;
        int n;

        // R1: reset values
        do_reset();
        #1;
        chk("R1 state", state, S_PO);
        chk("R1 busy", busy, 0);
        chk("R1 violation", violation, 0);

        // Sweep: every start condition against every input combination
        for (int s = 0; s < 10; s++) begin
            for (int c = 0; c < 2; c++) begin
                for (int cs = 0; cs < 2; cs++) begin
                    for (int k = 0; k < 8; k++) begin
                        do_reset();
                        ie = 1'b1; pv = 1'b1; st = S_PO;
                        case (s)
                            0: pv = 1'b0;
                            1: step(1, 1, K_NOP);
                            2: begin reach_idle(); st = S_IDLE; end
                            3: begin reach_idle(); step(1, 0, K_ACT); st = S_ACT; end
                            4: begin reach_resetting(); st = S_RST; ie = 1'b0; end
                            5: begin reach_idle(); step(1, 0, K_ACT); step(0, 1, K_NOP); st = S_APD; pv = 1'b0; end
                            6: begin reach_idle(); step(0, 1, K_NOP); st = S_IPD; pv = 1'b0; end
                            7: begin reach_idle(); step(0, 0, K_SREF); st = S_SR; pv = 1'b0; end
                            8: begin reach_idle(); step(0, 0, K_DPD); st = S_DPD; pv = 1'b0; end
                            default: begin reach_resetting(); step(0, 1, K_NOP); st = S_RPD; pv = 1'b0; ie = 1'b0; end
                        endcase
                        step(logic'(c), logic'(cs), 3'(k));
                        m = model(st, pv, logic'(c), logic'(cs), 3'(k), ie);
                        if (!pv && !c)     tag = "R6 R11 R9";
                        else if (!pv && c) tag = "R7 R11 R9";
                        else if (pv && !c) tag = "R4 R5 R9";
                        else               tag = "R2 R3 R9";
                        chk($sformatf("%s state st=%0d p=%0d c=%0d cs=%0d k=%0d", tag, st, pv, c, cs, k),
                            state, m[3:0]);
                        chk($sformatf("%s violation st=%0d p=%0d c=%0d cs=%0d k=%0d", tag, st, pv, c, cs, k),
                            violation, !m[4]);
                    end
                end
            end
        end

        // R8: power-down exit window of 3 cycles, command allowed right after
        do_reset();
        reach_idle();
        txp = 4'd3;
        step(0, 1, K_NOP);
        step(1, 1, K_NOP);
        n = 0;
        while (busy && n < 20) begin n++; step(1, 1, K_NOP); end
        chk("R8 txp busy length", n, 3);
        step(1, 0, K_ACT);
        chk("R8 command after window state", state, S_ACT);
        chk("R8 command after window violation", violation, 0);

        // R8: command on the last busy cycle is rejected
        do_reset();
        reach_idle();
        txp = 4'd3;
        step(0, 1, K_NOP);
        step(1, 1, K_NOP);
        step(1, 1, K_NOP);
        step(1, 1, K_NOP);
        chk("R8 last busy cycle", busy, 1);
        step(1, 0, K_ACT);
        chk("R8 early command state", state, S_IDLE);
        chk("R8 early command violation", violation, 1);

        // R10: flag survives legal traffic
        step(1, 0, K_ACT);
        step(1, 0, K_PREA);
        step(0, 1, K_NOP);
        step(1, 1, K_NOP);
        chk("R10 sticky state", state, S_IDLE);
        chk("R10 sticky violation", violation, 1);
        do_reset();
        #1;
        chk("R10 R1 cleared by reset", violation, 0);

        // R8: self-refresh exit uses its own 5-cycle window
        do_reset();
        reach_idle();
        txp = 4'd2;
        txsr = 4'd5;
        step(0, 0, K_SREF);
        step(0, 0, K_NOP);
        step(1, 1, K_NOP);
        chk("R8 self-refresh exit state", state, S_IDLE);
        n = 0;
        while (busy && n < 20) begin n++; step(1, 1, K_NOP); end
        chk("R8 txsr busy length", n, 5);
        chk("R8 txsr window violation", violation, 0);

        // R3: resetting lasts tinit5+1 sampled cycles
        do_reset();
        tinit = 4'd4;
        step(1, 1, K_NOP);
        step(1, 0, K_RST);
        n = 0;
        while (state == S_RST && n < 30) begin n++; step(1, 1, K_NOP); end
        chk("R3 resetting length", n, 5);
        chk("R3 end state", state, S_IDLE);
        chk("R3 violation", violation, 0);

        // R7: resetting power-down exit after the interval expired
        do_reset();
        tinit = 4'd2;
        step(1, 1, K_NOP);
        step(1, 0, K_RST);
        step(0, 1, K_NOP);
        chk("R4 resetting power-down entry", state, S_RPD);
        for (int i = 0; i < 4; i++) step(0, 0, K_NOP);
        step(1, 1, K_NOP);
        chk("R7 expired exit state", state, S_IDLE);
        chk("R7 expired exit violation", violation, 0);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule